// File: doc/BRIEF.md
# Instruction Length Decoder for a Byte-Lane Fetch Window

This block examines a window of fetched instruction bytes, handed over as sixteen byte lanes together with a count of how many of them are valid. It decodes the first instruction in the window under 32-bit default operand and address size. It reports the total length of that instruction and the boundaries of its fields. Lane 0 holds the first byte of the window. A front end uses the result to steer the next window start and to hand the split fields to a later decode stage.

The decoder works through a chain of dependent decisions. It scans up to four legacy prefixes and recognises a 0Fh escape. It then classifies the opcode, finds out whether a ModRM byte and a SIB byte follow, sizes the displacement from the addressing fields, and sizes the immediate from the opcode and the operand-size prefix. Opcode coverage is limited to the register/memory ADD forms, the accumulator-immediate ADD forms and the immediate group at 80h, 81h and 83h. Every other opcode, including every two-byte opcode, is reported as unsupported.

Each request is accepted with a one-cycle strobe, and the result is registered. The status output takes one of four values: decoded, more bytes needed, length fault, or unsupported. A length appears only with the decoded status.

Top module: `ild_top`

## Requirements
- R1: A result appears on the outputs, with `out_vld` high, exactly one clock after a cycle with `in_vld` high. `out_vld` is low in the cycle after any cycle with `in_vld` low, and it is low out of reset.
- R2: The bytes 66h, 67h, F0h, F2h, F3h, 26h, 2Eh, 36h, 3Eh, 64h and 65h count as prefixes while they run unbroken from lane 0. `out_pfx_cnt` gives the number of prefixes (0..4). The flags mark 66h (`out_pfx_opsz`), 67h (`out_pfx_adsz`), any of F0h/F2h/F3h (`out_pfx_lockrep`) and any segment override (`out_pfx_seg`). A repeated prefix byte counts every time it appears.
- R3: A fifth prefix gives status 2 (length fault). Any decoded length above 15 also gives status 2. A legal instruction of exactly 15 bytes decodes with status 0.
- R4: An opcode byte of 0Fh sets `out_two_byte` and puts the byte that follows it on `out_opcode`. The status is then 3 (unsupported), or 1 if that second byte lies outside the valid count.
- R5: ModRM is split as mode in bits [7:6], register in bits [5:3] and r/m in bits [2:0]. A SIB byte follows the ModRM byte exactly when the mode is not 11b and r/m is 100b.
- R6: The displacement size is 1 byte for mode 01b and 4 bytes for mode 10b. For mode 00b it is 4 bytes when r/m is 101b, or when a SIB byte is present and its base field (bits [2:0]) is 101b; otherwise it is 0. Mode 11b has no displacement.
- R7: Opcodes 80h and 83h carry a 1-byte immediate. Opcode 81h carries a 4-byte immediate, or a 2-byte immediate when 66h is present.
- R8: Opcode 04h has no ModRM byte and carries a 1-byte immediate. Opcode 05h has no ModRM byte and carries a 4-byte immediate, or a 2-byte immediate under 66h.
- R9: The following give status 3: any opcode outside 00h..05h, 80h, 81h and 83h; an 80h/81h/83h group byte whose ModRM register field is not 000b; and any ModRM-using opcode preceded by 67h.
- R10: When the valid count ends before the bytes needed to finish the decode, the status is 1 (more bytes needed). A count of zero also gives status 1.
- R11: With status 0, `out_len` equals prefixes + opcode + ModRM + SIB + displacement + immediate. With any other status, `out_len` is 0. Status codes are 0 decoded, 1 more bytes needed, 2 length fault, 3 unsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Decode request strobe |
| in_bytes | input | 128 | Byte window, lane i in bits [8i+7:8i] |
| in_cnt | input | 5 | Number of valid lanes (0..16) |
| out_vld | output | 1 | Result valid |
| out_status | output | 2 | 0 decoded, 1 more bytes, 2 length fault, 3 unsupported |
| out_len | output | 5 | Instruction length in bytes when decoded |
| out_pfx_cnt | output | 3 | Number of prefixes scanned |
| out_pfx_opsz | output | 1 | Operand-size prefix seen |
| out_pfx_adsz | output | 1 | Address-size prefix seen |
| out_pfx_lockrep | output | 1 | Lock or repeat prefix seen |
| out_pfx_seg | output | 1 | Segment override prefix seen |
| out_two_byte | output | 1 | Escape opcode seen |
| out_opcode | output | 8 | Final opcode byte |
| out_modrm_vld | output | 1 | ModRM byte present |
| out_modrm | output | 8 | ModRM byte |
| out_sib_vld | output | 1 | SIB byte present |
| out_sib | output | 8 | SIB byte |
| out_disp_sz | output | 3 | Displacement size in bytes |
| out_imm_sz | output | 3 | Immediate size in bytes |

## Verification
On every cycle the assertions check the strobe-to-result latency and that a decoded length stays between 1 and 15. They also check that a SIB byte never appears without ModRM, that the displacement size is always 0, 1 or 4, and that a decoded accumulator form never claims a ModRM byte. Further per-cycle checks cover the group register field on decoded group forms and that the length reads zero whenever the status is not decoded. Only the bench scenarios can show that lengths and field sizes are correct for particular byte patterns. Those scenarios cover the SIB-base and r/m-101b displacement quirks, the operand-size effect on immediates, the exact 15-byte boundary, fifth-prefix faults, and the split between more-bytes and unsupported for truncated windows.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_MORE  = 2'd1,
    ST_FAULT = 2'd2,
    ST_UNSUP = 2'd3
  } ild_status_e;

  typedef struct packed {
    logic opsz;
    logic adsz;
    logic lockrep;
    logic seg;
  } pfx_flags_t;

  localparam logic [7:0] OP_ESCAPE = 8'h0F;

  function automatic logic is_seg_pfx(input logic [7:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) ||
           (b == 8'h3E) || (b == 8'h64) || (b == 8'h65);
  endfunction

  function automatic logic is_lockrep_pfx(input logic [7:0] b);
    return (b == 8'hF0) || (b == 8'hF2) || (b == 8'hF3);
  endfunction

  function automatic logic is_any_pfx(input logic [7:0] b);
    return is_seg_pfx(b) || is_lockrep_pfx(b) || (b == 8'h66) || (b == 8'h67);
  endfunction

endpackage

// File: rtl/ild_pfx_scan.sv
module ild_pfx_scan
  import ild_pkg::*;
#(
  parameter int NLANE  = 16,
  parameter int MAXPFX = 4,
  parameter int CW     = $clog2(NLANE + 1),
  parameter int PCW    = $clog2(MAXPFX + 2)
) (
  input  logic [NLANE*8-1:0] bytes_i,
  input  logic [CW-1:0]      cnt_i,
  output logic [PCW-1:0]     pfx_n_o,
  output logic               over_o,
  output pfx_flags_t         flags_o
);

  logic           run;
  logic [7:0]     b;
  logic [PCW-1:0] n;
  pfx_flags_t     fl;

  // Unbroken run of prefix bytes from lane 0, one lane beyond the limit
  always_comb begin
    run = 1'b1;
    n   = '0;
    fl  = '0;
    b   = '0;
    for (int i = 0; i <= MAXPFX; i++) begin
      b = bytes_i[i*8 +: 8];
      if (run && (i < int'(cnt_i)) && is_any_pfx(b)) begin
        n = n + PCW'(1);
        if (b == 8'h66)        fl.opsz    = 1'b1;
        if (b == 8'h67)        fl.adsz    = 1'b1;
        if (is_lockrep_pfx(b)) fl.lockrep = 1'b1;
        if (is_seg_pfx(b))     fl.seg     = 1'b1;
      end else begin
        run = 1'b0;
      end
    end
  end

  assign pfx_n_o = n;
  assign over_o  = (int'(n) > MAXPFX);
  assign flags_o = fl;

endmodule

// File: rtl/ild_opclass.sv
module ild_opclass (
  input  logic [7:0] op_i,
  input  logic       opsz_i,
  output logic       known_o,
  output logic       uses_modrm_o,
  output logic       is_grp_o,
  output logic [2:0] imm_sz_o
);

  logic [2:0] full_imm;
  assign full_imm = opsz_i ? 3'd2 : 3'd4;

  always_comb begin
    known_o      = 1'b1;
    uses_modrm_o = 1'b0;
    is_grp_o     = 1'b0;
    imm_sz_o     = 3'd0;
    case (op_i)
      8'h00, 8'h01, 8'h02, 8'h03: uses_modrm_o = 1'b1;
      8'h04: imm_sz_o = 3'd1;
      8'h05: imm_sz_o = full_imm;
      8'h80, 8'h83: begin
        uses_modrm_o = 1'b1;
        is_grp_o     = 1'b1;
        imm_sz_o     = 3'd1;
      end
      8'h81: begin
        uses_modrm_o = 1'b1;
        is_grp_o     = 1'b1;
        imm_sz_o     = full_imm;
      end
      default: known_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ild_addr.sv
module ild_addr (
  input  logic [7:0] modrm_i,
  input  logic [7:0] sib_i,
  output logic       sib_vld_o,
  output logic [2:0] disp_sz_o
);

  logic [1:0] md;
  logic [2:0] rm;
  logic [2:0] base;

  assign md   = modrm_i[7:6];
  assign rm   = modrm_i[2:0];
  assign base = sib_i[2:0];

  assign sib_vld_o = (md != 2'b11) && (rm == 3'b100);

  always_comb begin
    case (md)
      2'b00:   disp_sz_o = ((rm == 3'b101) || (sib_vld_o && base == 3'b101)) ? 3'd4 : 3'd0;
      2'b01:   disp_sz_o = 3'd1;
      2'b10:   disp_sz_o = 3'd4;
      default: disp_sz_o = 3'd0;
    endcase
  end

endmodule

// File: rtl/ild_top.sv
module ild_top
  import ild_pkg::*;
#(
  parameter int NLANE  = 16,
  parameter int MAXLEN = 15,
  parameter int MAXPFX = 4,
  parameter int CW     = $clog2(NLANE + 1),
  parameter int PCW    = $clog2(MAXPFX + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [NLANE*8-1:0] in_bytes,
  input  logic [CW-1:0]      in_cnt,
  output logic               out_vld,
  output logic [1:0]         out_status,
  output logic [CW-1:0]      out_len,
  output logic [PCW-1:0]     out_pfx_cnt,
  output logic               out_pfx_opsz,
  output logic               out_pfx_adsz,
  output logic               out_pfx_lockrep,
  output logic               out_pfx_seg,
  output logic               out_two_byte,
  output logic [7:0]         out_opcode,
  output logic               out_modrm_vld,
  output logic [7:0]         out_modrm,
  output logic               out_sib_vld,
  output logic [7:0]         out_sib,
  output logic [2:0]         out_disp_sz,
  output logic [2:0]         out_imm_sz
);

  localparam int IDXW = $clog2(NLANE);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  logic rst_q_n;
  assign rst_q_n = rst_sync[1];

  // Byte lanes
  logic [7:0] lane [NLANE];
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane[g] = in_bytes[g*8 +: 8];
  end

  // Stage 1: prefixes
  logic [PCW-1:0] pfx_n;
  logic           pfx_over;
  pfx_flags_t     pfx_fl;

  ild_pfx_scan #(.NLANE(NLANE), .MAXPFX(MAXPFX), .CW(CW), .PCW(PCW)) u_pfx (
    .bytes_i (in_bytes),
    .cnt_i   (in_cnt),
    .pfx_n_o (pfx_n),
    .over_o  (pfx_over),
    .flags_o (pfx_fl)
  );

  // Stage 2: opcode lane, escape, following lanes
  logic [IDXW-1:0] idx_op, idx_nx, idx_sb;
  logic [7:0]      op0, byte_nx, byte_sb;
  logic            escape;

  assign idx_op  = IDXW'(pfx_n);
  assign idx_nx  = idx_op + IDXW'(1);
  assign idx_sb  = idx_op + IDXW'(2);
  assign op0     = lane[idx_op];
  assign byte_nx = lane[idx_nx];
  assign byte_sb = lane[idx_sb];
  assign escape  = (op0 == OP_ESCAPE);

  logic       cls_known, cls_modrm, cls_grp;
  logic [2:0] cls_imm;

  ild_opclass u_cls (
    .op_i         (op0),
    .opsz_i       (pfx_fl.opsz),
    .known_o      (cls_known),
    .uses_modrm_o (cls_modrm),
    .is_grp_o     (cls_grp),
    .imm_sz_o     (cls_imm)
  );

  // Stage 3: addressing bytes
  logic       am_sib;
  logic [2:0] am_disp;

  ild_addr u_addr (
    .modrm_i   (byte_nx),
    .sib_i     (byte_sb),
    .sib_vld_o (am_sib),
    .disp_sz_o (am_disp)
  );

  // Stage 4: length and status
  logic            has_modrm, has_sib;
  logic [2:0]      disp_n, imm_n;
  logic [CW-1:0]   total, p_c;
  ild_status_e     st_n;

  assign has_modrm = !escape && cls_known && cls_modrm;
  assign has_sib   = has_modrm && am_sib;
  assign disp_n    = has_modrm ? am_disp : 3'd0;
  assign imm_n     = (!escape && cls_known) ? cls_imm : 3'd0;
  assign p_c       = CW'(pfx_n);
  assign total     = p_c + CW'(1) + CW'(has_modrm) + CW'(has_sib) + CW'(disp_n) + CW'(imm_n);

  always_comb begin
    if (pfx_over)                                        st_n = ST_FAULT;
    else if (in_cnt <= p_c)                              st_n = ST_MORE;
    else if (escape)                                     st_n = (in_cnt < p_c + CW'(2)) ? ST_MORE : ST_UNSUP;
    else if (!cls_known)                                 st_n = ST_UNSUP;
    else if (cls_modrm && (in_cnt < p_c + CW'(2)))       st_n = ST_MORE;
    else if (cls_modrm && (pfx_fl.adsz || (cls_grp && byte_nx[5:3] != 3'b000)))
                                                         st_n = ST_UNSUP;
    else if (int'(total) > MAXLEN)                       st_n = ST_FAULT;
    else if (in_cnt < total)                             st_n = ST_MORE;
    else                                                 st_n = ST_OK;
  end

  // Result registers
  logic            vld_q;
  ild_status_e     st_q;
  logic [CW-1:0]   len_q;
  logic [PCW-1:0]  pc_q;
  pfx_flags_t      fl_q;
  logic            two_q, mv_q, sv_q;
  logic [7:0]      op_q, m_q, s_q;
  logic [2:0]      d_q, i_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      st_q  <= ST_OK;
      len_q <= '0;
      pc_q  <= '0;
      fl_q  <= '0;
      two_q <= 1'b0;
      op_q  <= '0;
      mv_q  <= 1'b0;
      m_q   <= '0;
      sv_q  <= 1'b0;
      s_q   <= '0;
      d_q   <= '0;
      i_q   <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        st_q  <= st_n;
        len_q <= (st_n == ST_OK) ? total : '0;
        pc_q  <= pfx_n;
        fl_q  <= pfx_fl;
        two_q <= escape;
        op_q  <= escape ? byte_nx : op0;
        mv_q  <= has_modrm;
        m_q   <= byte_nx;
        sv_q  <= has_sib;
        s_q   <= byte_sb;
        d_q   <= disp_n;
        i_q   <= imm_n;
      end
    end
  end

  assign out_vld         = vld_q;
  assign out_status      = st_q;
  assign out_len         = len_q;
  assign out_pfx_cnt     = pc_q;
  assign out_pfx_opsz    = fl_q.opsz;
  assign out_pfx_adsz    = fl_q.adsz;
  assign out_pfx_lockrep = fl_q.lockrep;
  assign out_pfx_seg     = fl_q.seg;
  assign out_two_byte    = two_q;
  assign out_opcode      = op_q;
  assign out_modrm_vld   = mv_q;
  assign out_modrm       = m_q;
  assign out_sib_vld     = sv_q;
  assign out_sib         = s_q;
  assign out_disp_sz     = d_q;
  assign out_imm_sz      = i_q;

  // Assertions
  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld |=> out_vld); // R1
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_vld |=> !out_vld); // R1
  AST_PFX_BOUND: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld && out_status != 2'd2) |-> (int'(out_pfx_cnt) <= MAXPFX)); // R2
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld && out_status == 2'd0) |-> (out_len >= CW'(1) && int'(out_len) <= MAXLEN)); // R3
  AST_SIB_NEEDS_MODRM: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld && out_sib_vld) |-> out_modrm_vld); // R5
  AST_DISP_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_vld |-> (out_disp_sz == 3'd0 || out_disp_sz == 3'd1 || out_disp_sz == 3'd4)); // R6
  AST_ACC_NO_MODRM: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld && out_status == 2'd0 && (out_opcode == 8'h04 || out_opcode == 8'h05)) |-> !out_modrm_vld); // R8
  AST_GRP_REG_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld && out_status == 2'd0 && out_opcode[7]) |-> (out_modrm[5:3] == 3'b000)); // R9
  AST_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld && out_status != 2'd0) |-> (out_len == '0)); // R11

endmodule

// File: tb/ild_top_bench.sv
module ild_top_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [127:0] in_bytes = '0;
  logic [4:0]   in_cnt = '0;
  logic         out_vld;
  logic [1:0]   out_status;
  logic [4:0]   out_len;
  logic [2:0]   out_pfx_cnt;
  logic         out_pfx_opsz, out_pfx_adsz, out_pfx_lockrep, out_pfx_seg;
  logic         out_two_byte;
  logic [7:0]   out_opcode;
  logic         out_modrm_vld;
  logic [7:0]   out_modrm;
  logic         out_sib_vld;
  logic [7:0]   out_sib;
  logic [2:0]   out_disp_sz, out_imm_sz;

  always #2.5 clk = ~clk;

  ild_top u_ild_top (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bytes(in_bytes), .in_cnt(in_cnt),
    .out_vld(out_vld), .out_status(out_status), .out_len(out_len),
    .out_pfx_cnt(out_pfx_cnt), .out_pfx_opsz(out_pfx_opsz), .out_pfx_adsz(out_pfx_adsz),
    .out_pfx_lockrep(out_pfx_lockrep), .out_pfx_seg(out_pfx_seg),
    .out_two_byte(out_two_byte), .out_opcode(out_opcode),
    .out_modrm_vld(out_modrm_vld), .out_modrm(out_modrm),
    .out_sib_vld(out_sib_vld), .out_sib(out_sib),
    .out_disp_sz(out_disp_sz), .out_imm_sz(out_imm_sz)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] bq [16];

  // Expected values
  int m_st, m_len, m_pc, m_d, m_i;
  bit m_os, m_as, m_lr, m_sg, m_two, m_mv, m_sv;
  logic [7:0] m_op, m_m, m_s;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int cnt);
    int p;
    bit run;
    int tot;
    logic [7:0] b;
    bit known, grp;
    p = 0; run = 1; m_os = 0; m_as = 0; m_lr = 0; m_sg = 0;
    m_two = 0; m_mv = 0; m_sv = 0; m_d = 0; m_i = 0; m_len = 0;
    m_op = 0; m_m = 0; m_s = 0;
    for (int i = 0; i < 5; i++) begin
      b = bq[i];
      if (run && i < cnt && (b inside {8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
                                       8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65})) begin
        p++;
        if (b == 8'h66) m_os = 1;
        if (b == 8'h67) m_as = 1;
        if (b inside {8'hF0, 8'hF2, 8'hF3}) m_lr = 1;
        if (b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65}) m_sg = 1;
      end else run = 0;
    end
    m_pc = p;
    if (p == 5) begin m_st = 2; return; end
    if (cnt <= p) begin m_st = 1; return; end
    if (bq[p] == 8'h0F) begin
      m_two = 1; m_op = bq[p+1];
      m_st = (cnt < p + 2) ? 1 : 3;
      return;
    end
    m_op = bq[p]; known = 1; grp = 0;
    case (m_op)
      8'h00, 8'h01, 8'h02, 8'h03: m_mv = 1;
      8'h04: m_i = 1;
      8'h05: m_i = m_os ? 2 : 4;
      8'h80, 8'h83: begin m_mv = 1; grp = 1; m_i = 1; end
      8'h81: begin m_mv = 1; grp = 1; m_i = m_os ? 2 : 4; end
      default: known = 0;
    endcase
    if (!known) begin m_st = 3; m_mv = 0; m_i = 0; return; end
    if (m_mv) begin
      m_m = bq[p+1]; m_s = bq[p+2];
      if (cnt < p + 2) begin m_st = 1; return; end
      if (m_as || (grp && m_m[5:3] != 0)) begin m_st = 3; return; end
      m_sv = (m_m[7:6] != 2'b11) && (m_m[2:0] == 3'b100);
      if (m_m[7:6] == 2'b01) m_d = 1;
      else if (m_m[7:6] == 2'b10) m_d = 4;
      else if (m_m[7:6] == 2'b00 && (m_m[2:0] == 3'b101 || (m_sv && m_s[2:0] == 3'b101))) m_d = 4;
    end
    tot = p + 1 + int'(m_mv) + int'(m_sv) + m_d + m_i;
    if (tot > 15) m_st = 2;
    else if (cnt < tot) m_st = 1;
    else begin m_st = 0; m_len = tot; end
  endtask

  task automatic fill_junk();
    for (int i = 0; i < 16; i++) bq[i] = 8'($urandom);
  endtask

  task automatic ld(input int n, input logic [127:0] v);
    fill_junk();
    for (int i = 0; i < n; i++) bq[i] = v[(n-1-i)*8 +: 8];
  endtask

  // Drive one request and compare all fields against the model
  task automatic run_req(input int cnt, input string tag);
    @(negedge clk);
    for (int i = 0; i < 16; i++) in_bytes[i*8 +: 8] = bq[i];
    in_cnt = 5'(cnt);
    in_vld = 1'b1;
    model(cnt);
    @(negedge clk);
    in_vld = 1'b0;
    chk({tag, " R1 out_vld"}, int'(out_vld), 1);
    chk({tag, " R11 status"}, int'(out_status), m_st);
    chk({tag, " R11 len"}, int'(out_len), m_len);
    if (m_st == 0 || m_st == 3) begin
      chk({tag, " R2 pfx_cnt"}, int'(out_pfx_cnt), m_pc);
      chk({tag, " R2 flags"}, int'({out_pfx_opsz, out_pfx_adsz, out_pfx_lockrep, out_pfx_seg}),
          int'({m_os, m_as, m_lr, m_sg}));
      chk({tag, " R4 two_byte"}, int'(out_two_byte), int'(m_two));
      if (m_two) chk({tag, " R4 opcode"}, int'(out_opcode), int'(m_op));
    end
    if (m_st == 0) begin
      chk({tag, " R11 opcode"}, int'(out_opcode), int'(m_op));
      chk({tag, " R5 modrm_vld"}, int'(out_modrm_vld), int'(m_mv));
      if (m_mv) chk({tag, " R5 modrm"}, int'(out_modrm), int'(m_m));
      chk({tag, " R5 sib_vld"}, int'(out_sib_vld), int'(m_sv));
      if (m_sv) chk({tag, " R5 sib"}, int'(out_sib), int'(m_s));
      chk({tag, " R6 disp"}, int'(out_disp_sz), m_d);
      chk({tag, " R7 imm"}, int'(out_imm_sz), m_i);
    end
  endtask

  task automatic dir(input int n, input logic [127:0] v, input int cnt,
                     input int est, input int elen, input string tag);
    ld(n, v);
    run_req(cnt, tag);
    chk({tag, " direct status"}, int'(out_status), est);
    chk({tag, " direct len"}, int'(out_len), elen);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pfx_tab [11];
    logic [7:0] op_tab [12];
    pfx_tab = '{8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65};
    op_tab  = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h80, 8'h81, 8'h83, 8'h0F, 8'h82, 8'hC3};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset out_vld", int'(out_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle out_vld", int'(out_vld), 0);

    dir(2, 'h00C1, 16, 0, 2, "R5 reg-reg d0");
    dir(2, 'h02C8, 16, 0, 2, "R5 reg-reg d1");
    dir(3, 'h030CBB, 16, 0, 3, "R5 sib");
    dir(7, 'h032C0511223344, 16, 0, 7, "R6 sib base101");
    dir(6, 'h030D11223344, 16, 0, 6, "R6 rm101");
    dir(3, 'h014810, 16, 0, 3, "R6 disp8");
    dir(6, 'h018811223344, 16, 0, 6, "R6 disp32");
    dir(2, 'h047F, 16, 0, 2, "R8 acc imm8");
    dir(5, 'h0511223344, 16, 0, 5, "R8 acc imm32");
    dir(4, 'h66051122, 16, 0, 4, "R8 acc imm16");
    dir(3, 'h83C001, 16, 0, 3, "R7 83 imm8");
    dir(3, 'h80C005, 16, 0, 3, "R7 80 imm8");
    dir(6, 'h81C011223344, 16, 0, 6, "R7 81 imm32");
    dir(5, 'h6681C01122, 16, 0, 5, "R7 81 imm16");
    dir(6, 'h81C811223344, 16, 3, 0, "R9 group reg1");
    dir(3, 'h670100, 16, 3, 0, "R9 adsz modrm");
    dir(1, 'hC3, 16, 3, 0, "R9 unknown");
    dir(2, 'h0F58, 16, 3, 0, "R4 escape");
    chk("R4 escape opcode", int'(out_opcode), 8'h58);
    dir(2, 'h0F58, 1, 1, 0, "R4 escape short");
    dir(15, 'hF02E3E268184241122334455667788, 16, 0, 15, "R3 fifteen");
    dir(6, 'h666666666605, 16, 2, 0, "R3 fifth prefix");
    dir(6, 'hF2F2F2F2F204, 16, 2, 0, "R3 repeated prefix");
    dir(5, 'h0511223344, 3, 1, 0, "R10 short imm");
    dir(4, 'h66666666, 4, 1, 0, "R10 prefixes only");
    dir(2, 'h047F, 0, 1, 0, "R10 empty");
    dir(3, 'h030CBB, 2, 1, 0, "R10 missing sib");
    dir(7, 'h66F36467051122, 16, 0, 7, "R2 flags");
    chk("R2 flags value", int'({out_pfx_opsz, out_pfx_adsz, out_pfx_lockrep, out_pfx_seg}), 15);
    chk("R2 pfx count", int'(out_pfx_cnt), 4);
    @(negedge clk);
    chk("R1 drop out_vld", int'(out_vld), 0);

    for (int it = 0; it < 400; it++) begin
      int np, c;
      fill_junk();
      np = int'($urandom % 6);
      for (int k = 0; k < np; k++) bq[k] = pfx_tab[$urandom % 11];
      bq[np] = op_tab[$urandom % 12];
      if ($urandom % 2) bq[np+1][5:3] = 3'b000;
      c = ($urandom % 10 < 7) ? 16 : int'($urandom % 17);
      run_req(c, "random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule